// File: doc/BRIEF.md
# SPI NOR Flash Device Emulator

This block behaves like a small serial NOR flash memory sitting on an SPI bus as a slave in single-bit mode 0. A host drives chip select, serial clock and MOSI; the block answers on MISO. The storage is an on-chip byte array whose size is a parameter. The block is clocked by a system clock that is much faster than the serial clock, and it resamples the bus pins through synchronizer stages.

Each transaction starts with a one-byte opcode. Depending on the opcode, the block returns identification or status bytes, collects a 24-bit address and streams data out, or writes or erases storage. Modifying commands are gated by a write-enable latch, and they take effect immediately, with no busy period. Program writes each byte as it arrives and keeps the write pointer inside one page. Erase is applied when chip select rises. The identification capacity code is the base-2 logarithm of the storage size in bytes.

Top module: `spinor_emu`

## Requirements
- R1: After reset, every storage byte reads 0xFF, the status byte is 0x00, and MISO is held high while chip select (active low) is inactive.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns the status byte on every following byte: 0x02 (bit 1) while the latch is set, else 0x00.
- R3: Opcode 0x9F returns the manufacturer code (default 0x20), then the memory type code (default 0xBA), then the capacity code log2(storage bytes) (0x0A for the default 1024 bytes), and 0xFF on any further byte.
- R4: Opcode 0x03 takes a 3-byte address, most significant byte first. Only its low log2(size) bits select a byte. Data then streams from successive addresses, wrapping from the last byte to byte 0, until chip select rises.
- R5: Opcode 0x0B takes a 3-byte address and then one dummy byte. After that it streams data exactly as in R4.
- R6: Opcode 0x02 with the latch set takes a 3-byte address and then writes each following byte at the pointer. The pointer's offset within the page (default 16 bytes) wraps, so bytes past a page end overwrite earlier bytes of the same page.
- R7: Opcode 0xD8 with the latch set, followed by a full 3-byte address, sets to 0xFF every byte of the sector (default 256 bytes) that holds that address, aligned down to the sector size. No other byte changes.
- R8: Opcode 0x20 does the same as R7 for a sub-sector (default 64 bytes).
- R9: Opcode 0xC7 with the latch set sets every storage byte to 0xFF.
- R10: Program and all erases leave storage unchanged when the write-enable latch is clear.
- R11: An erase is applied at chip select rise, and only once its full address (if any) has arrived. A program that wrote bytes, or an erase that was applied, clears the latch at that rise. A command cut short leaves the latch set.
- R12: An unknown opcode is ignored until chip select rises: MISO stays 0xFF and the following bytes neither change the latch nor change storage.
- R13: Bytes move most significant bit first. MOSI is sampled on the rising edge of the serial clock, and MISO changes only after a falling edge, so it is stable while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores power-on state |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low (mode 0) |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high while deselected |

## Verification
The assertions assume the serial clock is slow enough that every rising and falling edge survives the synchronizers as a separate event. They also assume a received byte and a chip-select edge are never seen in the same system cycle. Under these assumptions, byte strobes, pointer steps and erase strobes have well-defined cycles to be compared against. The stimulus holds each serial clock phase for six system cycles, waits six cycles after lowering chip select before the first edge, and waits eight after raising it. Every edge therefore lands cleanly inside the synchronized view.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SECT  = 8'hD8;
  localparam logic [7:0] OP_SUB   = 8'h20;
  localparam logic [7:0] OP_CHIP  = 8'hC7;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    ST_OPC,     // waiting for opcode
    ST_ADDR,    // collecting address bytes
    ST_DUMMY,   // fast-read dummy byte
    ST_STREAM,  // sending data bytes
    ST_IDENT,   // sending identification bytes
    ST_STATUS,  // sending status bytes
    ST_PROG,    // accepting program data
    ST_ARMED,   // erase waits for chip select rise
    ST_SKIP     // ignore until deselect
  } dec_state_e;

  // Clear the low bits of an address so it points at a block start.
  function automatic logic [23:0] align_down(input logic [23:0] a, input int unsigned blk);
    logic [23:0] low;
    low = 24'(blk) - 24'd1;
    return a & ~low;
  endfunction

  // Next program pointer: the offset inside the page advances and wraps.
  function automatic logic [23:0] step_in_page(input logic [23:0] a, input int unsigned pg);
    logic [23:0] low;
    low = 24'(pg) - 24'd1;
    return (a & ~low) | ((a + 24'd1) & low);
  endfunction

  // Status byte: write-enable latch in bit 1.
  function automatic logic [7:0] status_of(input logic wel);
    return {6'b000000, wel, 1'b0};
  endfunction

endpackage

// File: rtl/spinor_link.sv
module spinor_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  input  logic [7:0] tx_byte,
  output logic       spi_miso,
  output logic       sel_start,
  output logic       sel_end,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  import spinor_pkg::*;

  logic [SYNC_STAGES-1:0] cs_pipe, ck_pipe, di_pipe;
  logic cs_s, ck_s, di_s, cs_d, ck_d;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            cs_pipe[0] <= 1'b1; ck_pipe[0] <= 1'b0; di_pipe[0] <= 1'b0;
          end else begin
            cs_pipe[0] <= spi_cs_n; ck_pipe[0] <= spi_sclk; di_pipe[0] <= spi_mosi;
          end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            cs_pipe[g] <= 1'b1; ck_pipe[g] <= 1'b0; di_pipe[g] <= 1'b0;
          end else begin
            cs_pipe[g] <= cs_pipe[g-1]; ck_pipe[g] <= ck_pipe[g-1]; di_pipe[g] <= di_pipe[g-1];
          end
      end
    end
  endgenerate

  assign cs_s = cs_pipe[SYNC_STAGES-1];
  assign ck_s = ck_pipe[SYNC_STAGES-1];
  assign di_s = di_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_d <= 1'b1; ck_d <= 1'b0;
    end else begin
      cs_d <= cs_s; ck_d <= ck_s;
    end

  logic sck_rise, sck_fall;
  assign sel_start = cs_d & ~cs_s;
  assign sel_end   = ~cs_d & cs_s;
  assign sck_rise  = ck_s & ~ck_d & ~cs_s;
  assign sck_fall  = ~ck_s & ck_d & ~cs_s;

  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; rx_sh <= '0; rx_byte <= '0; rx_valid <= 1'b0; tx_sh <= IDLE_BYTE;
    end else if (sel_start) begin
      bit_cnt <= '0; rx_valid <= 1'b0; tx_sh <= IDLE_BYTE;
    end else begin
      rx_valid <= 1'b0;
      if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], di_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_byte  <= {rx_sh, di_s};
          rx_valid <= 1'b1;
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) tx_sh <= tx_byte;
        else                 tx_sh <= {tx_sh[6:0], 1'b1};
      end
    end

  assign spi_miso = cs_s ? 1'b1 : tx_sh[7];

  // R13: a byte boundary always follows a sampling edge
  assert_byte_on_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sck_rise));
  // R13: a new selection starts on a byte boundary
  assert_frame_align_R13: assert property (@(posedge clk) disable iff (!rst_n)
    sel_start |=> (bit_cnt == 3'd0));
  // R13: MISO holds while the serial clock stays high
  assert_miso_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && $past(!cs_s) && ck_s && $past(ck_s)) |-> $stable(spi_miso));

endmodule

// File: rtl/spinor_store.sv
module spinor_store #(
  parameter int BYTES = 1024,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          ers_en,
  input  logic [AW-1:0] ers_base,
  input  logic [AW-1:0] ers_keep,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] cells [BYTES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) cells[i] <= 8'hFF;
    end else if (ers_en) begin
      for (int i = 0; i < BYTES; i++)
        if ((AW'(i) & ers_keep) == (ers_base & ers_keep)) cells[i] <= 8'hFF;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end

  assign rd_data = cells[rd_addr];

  // R7: the addressed byte of an erased block reads blank next cycle
  assert_erase_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ers_en |=> (cells[$past(ers_base)] == 8'hFF));
  // R6: a program strobe lands its byte
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ers_en) |=> (cells[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/spinor_ctrl.sv
module spinor_ctrl #(
  parameter int          AW        = 10,
  parameter int          SECTOR    = 256,
  parameter int          SUBSECTOR = 64,
  parameter int          PAGE      = 16,
  parameter logic [7:0]  MFR_CODE  = 8'h20,
  parameter logic [7:0]  TYPE_CODE = 8'hBA,
  parameter logic [7:0]  CAP_CODE  = 8'h0A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_start,
  input  logic          sel_end,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic [7:0]    rd_data,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          ers_en,
  output logic [AW-1:0] ers_base,
  output logic [AW-1:0] ers_keep,
  output logic          wel
);
  import spinor_pkg::*;

  localparam logic [AW-1:0] SECT_KEEP = ~AW'(SECTOR - 1);
  localparam logic [AW-1:0] SUB_KEEP  = ~AW'(SUBSECTOR - 1);

  dec_state_e  state;
  logic [7:0]  opc;
  logic [23:0] addr_acc, addr_full, ptr;
  logic [1:0]  addr_cnt, id_idx;
  logic        prog_hit;

  assign addr_full = {addr_acc[15:0], rx_byte};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_OPC; opc <= 8'h00; addr_acc <= '0; addr_cnt <= '0;
      ptr <= '0; id_idx <= '0; wel <= 1'b0; prog_hit <= 1'b0;
    end else if (sel_start) begin
      state <= ST_OPC; addr_cnt <= '0; prog_hit <= 1'b0;
    end else if (sel_end) begin
      if (wel && (state == ST_ARMED || prog_hit)) wel <= 1'b0;
      state <= ST_OPC; prog_hit <= 1'b0;
    end else if (rx_valid) begin
      case (state)
        ST_OPC: begin
          opc <= rx_byte;
          addr_cnt <= '0;
          case (rx_byte)
            OP_WEN:   begin wel <= 1'b1; state <= ST_SKIP; end
            OP_WDIS:  begin wel <= 1'b0; state <= ST_SKIP; end
            OP_IDENT: begin id_idx <= '0; state <= ST_IDENT; end
            OP_STAT:  state <= ST_STATUS;
            OP_READ, OP_FAST, OP_PROG, OP_SECT, OP_SUB: state <= ST_ADDR;
            OP_CHIP:  state <= ST_ARMED;
            default:  state <= ST_SKIP;
          endcase
        end
        ST_ADDR: begin
          addr_acc <= addr_full;
          addr_cnt <= addr_cnt + 2'd1;
          if (addr_cnt == 2'd2) begin
            ptr <= addr_full;
            case (opc)
              OP_READ: state <= ST_STREAM;
              OP_FAST: state <= ST_DUMMY;
              OP_PROG: state <= ST_PROG;
              default: state <= ST_ARMED;
            endcase
          end
        end
        ST_DUMMY:  state <= ST_STREAM;
        ST_STREAM: ptr <= ptr + 24'd1;
        ST_IDENT:  if (id_idx != 2'd3) id_idx <= id_idx + 2'd1;
        ST_PROG: begin
          if (wel) begin
            prog_hit <= 1'b1;
            ptr <= step_in_page(ptr, PAGE);
          end
        end
        default: ;
      endcase
    end

  // Storage strobes
  assign wr_en   = (state == ST_PROG) && rx_valid && wel && !sel_start && !sel_end;
  assign wr_addr = ptr[AW-1:0];
  assign wr_data = rx_byte;
  assign rd_addr = ptr[AW-1:0];
  assign ers_en  = sel_end && (state == ST_ARMED) && wel;

  always_comb begin
    ers_base = addr_acc[AW-1:0];
    case (opc)
      OP_SECT: ers_keep = SECT_KEEP;
      OP_SUB:  ers_keep = SUB_KEEP;
      default: ers_keep = '0;
    endcase
  end

  // Byte presented for the next outgoing slot
  always_comb begin
    case (state)
      ST_STREAM: tx_byte = rd_data;
      ST_STATUS: tx_byte = status_of(wel);
      ST_IDENT: begin
        case (id_idx)
          2'd0:    tx_byte = MFR_CODE;
          2'd1:    tx_byte = TYPE_CODE;
          2'd2:    tx_byte = CAP_CODE;
          default: tx_byte = IDLE_BYTE;
        endcase
      end
      default: tx_byte = IDLE_BYTE;
    endcase
  end

  // R11: a completed modify drops the latch
  assert_wel_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_end && wel && (state == ST_ARMED || prog_hit)) |=> !wel);
  // R6: the program pointer never leaves its page
  assert_page_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && rx_valid && !sel_start && !sel_end)
      |=> (align_down(ptr, PAGE) == align_down($past(ptr), PAGE)));
  // R4: each streamed byte advances the read pointer by one
  assert_stream_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STREAM && rx_valid && !sel_start && !sel_end)
      |=> (rd_addr == $past(rd_addr) + AW'(1)));
  // R12: an ignored command never touches the latch
  assert_skip_keeps_wel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP && !sel_start && !sel_end) |=> $stable(wel));

endmodule

// File: rtl/spinor_emu.sv
module spinor_emu #(
  parameter int         MEM_BYTES       = 1024,
  parameter int         SECTOR_BYTES    = 256,
  parameter int         SUBSECTOR_BYTES = 64,
  parameter int         PAGE_BYTES      = 16,
  parameter logic [7:0] MFR_CODE        = 8'h20,
  parameter logic [7:0] TYPE_CODE       = 8'hBA,
  parameter int         SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sclk,
  input  logic spi_mosi,
  output logic spi_miso
);

  localparam int         AW       = $clog2(MEM_BYTES);
  localparam logic [7:0] CAP_CODE = 8'(AW);

  logic          sel_start, sel_end, rx_valid;
  logic [7:0]    rx_byte, tx_byte, rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr, ers_base, ers_keep;
  logic          wr_en, ers_en, wel;

  spinor_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .tx_byte(tx_byte), .spi_miso(spi_miso),
    .sel_start(sel_start), .sel_end(sel_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  spinor_ctrl #(
    .AW(AW), .SECTOR(SECTOR_BYTES), .SUBSECTOR(SUBSECTOR_BYTES), .PAGE(PAGE_BYTES),
    .MFR_CODE(MFR_CODE), .TYPE_CODE(TYPE_CODE), .CAP_CODE(CAP_CODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sel_start(sel_start), .sel_end(sel_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_data(rd_data),
    .tx_byte(tx_byte), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ers_en(ers_en), .ers_base(ers_base), .ers_keep(ers_keep),
    .wel(wel)
  );

  spinor_store #(.BYTES(MEM_BYTES), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ers_en(ers_en), .ers_base(ers_base), .ers_keep(ers_keep),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R10: storage is only modified while the latch, set by an earlier byte, holds
  assert_modify_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || ers_en) |-> $past(wel));
  // R1: deselected bus reads high
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_cs_n, SYNC_STAGES + 1) && spi_cs_n && $past(spi_cs_n)) |-> spi_miso);

endmodule

// File: tb/spinor_emu_test.sv
module spinor_emu_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_miso;

  always #4 clk = ~clk; // 125 MHz

  spinor_emu uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;
  logic timing_bad = 1'b0;
  logic [7:0] wbuf [0:19];
  logic [7:0] rbuf [0:19];
  logic [7:0] page_model [0:15];

  localparam logic [3:0] K_WEN = 4'd0, K_WDIS = 4'd1, K_STAT = 4'd2, K_PROG = 4'd3,
                         K_READ = 4'd4, K_FAST = 4'd5, K_SECT = 4'd6, K_SUB = 4'd7,
                         K_CHIP = 4'd8;
  // {kind, requirement, address, value}
  localparam int NV = 34;
  localparam logic [39:0] VEC [NV] = '{
    {K_STAT, 4'd1,  24'h000000, 8'h00},  // R1 status after reset
    {K_WEN,  4'd2,  24'h000000, 8'h00},
    {K_STAT, 4'd2,  24'h000000, 8'h02},  // R2 latch set
    {K_WDIS, 4'd2,  24'h000000, 8'h00},
    {K_STAT, 4'd2,  24'h000000, 8'h00},  // R2 latch clear
    {K_WEN,  4'd6,  24'h000000, 8'h00},
    {K_PROG, 4'd6,  24'h000105, 8'h3C},  // R6
    {K_STAT, 4'd11, 24'h000000, 8'h00},  // R11 latch dropped
    {K_READ, 4'd4,  24'h000105, 8'h3C},  // R4
    {K_FAST, 4'd5,  24'h000105, 8'h3C},  // R5
    {K_READ, 4'd4,  24'hFF0105, 8'h3C},  // R4 high address bits unused
    {K_PROG, 4'd10, 24'h000106, 8'h55},  // R10 no latch
    {K_READ, 4'd10, 24'h000106, 8'hFF},
    {K_WEN,  4'd8,  24'h000000, 8'h00},
    {K_PROG, 4'd8,  24'h000140, 8'h77},
    {K_WEN,  4'd7,  24'h000000, 8'h00},
    {K_PROG, 4'd7,  24'h0002C0, 8'hA5},
    {K_WEN,  4'd8,  24'h000000, 8'h00},
    {K_SUB,  4'd8,  24'h000107, 8'h00},  // R8 erases 0x100..0x13F
    {K_STAT, 4'd11, 24'h000000, 8'h00},
    {K_READ, 4'd8,  24'h000105, 8'hFF},
    {K_READ, 4'd8,  24'h000140, 8'h77},
    {K_SECT, 4'd10, 24'h000150, 8'h00},  // R10 no latch
    {K_READ, 4'd10, 24'h000140, 8'h77},
    {K_WEN,  4'd7,  24'h000000, 8'h00},
    {K_SECT, 4'd7,  24'h0001FF, 8'h00},  // R7 erases 0x100..0x1FF
    {K_READ, 4'd7,  24'h000140, 8'hFF},
    {K_READ, 4'd7,  24'h0002C0, 8'hA5},
    {K_CHIP, 4'd10, 24'h000000, 8'h00},  // R10 no latch
    {K_READ, 4'd10, 24'h0002C0, 8'hA5},
    {K_WEN,  4'd9,  24'h000000, 8'h00},
    {K_CHIP, 4'd9,  24'h000000, 8'h00},  // R9
    {K_READ, 4'd9,  24'h0002C0, 8'hFF},
    {K_STAT, 4'd11, 24'h000000, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic m;
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = tx[b];
      repeat (6) @(negedge clk);
      m = spi_miso;
      spi_sclk = 1'b1;
      repeat (3) @(negedge clk);
      if (spi_miso !== m) timing_bad = 1'b1;
      repeat (3) @(negedge clk);
      if (spi_miso !== m) timing_bad = 1'b1;
      rx[b] = m;
      spi_sclk = 1'b0;
    end
  endtask

  task automatic sel();
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic desel();
    spi_sclk = 1'b0;
    repeat (6) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic op_only(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic get_status(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'hFF, s); desel();
  endtask

  task automatic read_n(input bit fast, input logic [23:0] a, input int n);
    logic [7:0] d;
    sel();
    xfer(fast ? 8'h0B : 8'h03, d);
    send_addr(a);
    if (fast) xfer(8'hFF, d);
    for (int i = 0; i < n; i++) xfer(8'hFF, rbuf[i]);
    desel();
  endtask

  task automatic prog_n(input logic [23:0] a, input int n);
    logic [7:0] d;
    sel(); xfer(8'h02, d); send_addr(a);
    for (int i = 0; i < n; i++) xfer(wbuf[i], d);
    desel();
  endtask

  task automatic erase(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    sel(); xfer(op, d);
    if (op != 8'hC7) send_addr(a);
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R13 watchdog expired: actual running expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check("R1 miso idle", {7'd0, spi_miso}, 8'h01);
    read_n(1'b0, 24'h0003AB, 1);
    check("R1 blank storage", rbuf[0], 8'hFF);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [3:0] k; logic [3:0] rq; logic [23:0] a; logic [7:0] val;
      string tag;
      {k, rq, a, val} = VEC[v];
      tag = $sformatf("R%0d vector %0d", rq, v);
      case (k)
        K_WEN:  op_only(8'h06);
        K_WDIS: op_only(8'h04);
        K_STAT: begin get_status(s); check(tag, s, val); end
        K_PROG: begin wbuf[0] = val; prog_n(a, 1); end
        K_READ: begin read_n(1'b0, a, 1); check(tag, rbuf[0], val); end
        K_FAST: begin read_n(1'b1, a, 1); check(tag, rbuf[0], val); end
        K_SECT: erase(8'hD8, a);
        K_SUB:  erase(8'h20, a);
        K_CHIP: erase(8'hC7, a);
        default: ;
      endcase
    end

    // R3 identification
    sel();
    xfer(8'h9F, d);
    xfer(8'hFF, s); check("R3 manufacturer", s, 8'h20);
    xfer(8'hFF, s); check("R3 memory type", s, 8'hBA);
    xfer(8'hFF, s); check("R3 capacity", s, 8'h0A);
    xfer(8'hFF, s); check("R3 past end", s, 8'hFF);
    desel();

    // R4 streaming across the end of storage
    op_only(8'h06);
    wbuf[0] = 8'hB1; wbuf[1] = 8'hB2;
    prog_n(24'h0003FE, 2);
    read_n(1'b0, 24'h0003FE, 3);
    check("R4 stream byte 0", rbuf[0], 8'hB1);
    check("R4 stream byte 1", rbuf[1], 8'hB2);
    check("R4 wrap to zero", rbuf[2], 8'hFF);

    // R6 page wrap: 18 bytes starting at offset 14 of a 16-byte page
    for (int i = 0; i < 16; i++) page_model[i] = 8'hFF;
    for (int i = 0; i < 18; i++) begin
      wbuf[i] = 8'(i + 1);
      page_model[(14 + i) % 16] = 8'(i + 1);
    end
    op_only(8'h06);
    prog_n(24'h00020E, 18);
    read_n(1'b0, 24'h000200, 16);
    for (int i = 0; i < 16; i++)
      check($sformatf("R6 page offset %0d", i), rbuf[i], page_model[i]);

    // R5 fast read with several bytes
    read_n(1'b1, 24'h000200, 2);
    check("R5 fast byte 0", rbuf[0], page_model[0]);
    check("R5 fast byte 1", rbuf[1], page_model[1]);

    // R12 unknown opcode followed by bytes that look like commands
    op_only(8'h06);
    sel();
    xfer(8'h5A, s); check("R12 miso after unknown", s, 8'hFF);
    xfer(8'h04, s); check("R12 miso ignored 1", s, 8'hFF);
    xfer(8'hC7, s); check("R12 miso ignored 2", s, 8'hFF);
    desel();
    get_status(s); check("R12 latch kept", s, 8'h02);
    read_n(1'b0, 24'h000200, 1); check("R12 storage kept", rbuf[0], page_model[0]);

    // R11 erase cut short before its address completes
    sel(); xfer(8'hD8, d); xfer(8'h00, d); xfer(8'h02, d); desel();
    read_n(1'b0, 24'h000200, 1); check("R11 truncated erase no effect", rbuf[0], page_model[0]);
    get_status(s); check("R11 latch kept after truncation", s, 8'h02);

    // R1 reset mid-run restores power-on state
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    get_status(s); check("R1 latch after reset", s, 8'h00);
    read_n(1'b0, 24'h000200, 1); check("R1 storage after reset", rbuf[0], 8'hFF);

    // R13 MISO stable through every high phase
    check("R13 miso stable while clock high", {7'd0, timing_bad}, 8'h00);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule